// File: doc/BRIEF.md
# Double-Buffered Octal Converter Register Front End

This block is the digital side of an eight-channel, 14-bit voltage converter that is written like a memory. A 3-bit channel address and a 14-bit code arrive on a parallel bus, and four active-low strobes control the block: chip-select, write, load and clear. Each channel has two register ranks. The input rank takes new codes from the bus. The output rank holds the code that the analog stage converts. A global load moves the input rank into the output rank for all channels at once, so every channel can switch together.

All strobes, the address and the data pass through a two-flop synchronizer into the system clock domain. The transparent-latch behaviour is rebuilt as registers that update on every clock while their enabling condition holds. Clear is non-destructive. While it is asserted, a per-channel force flag tells the analog stage to drive its ground-sense level. No stored code is changed, so the held codes come back as soon as clear is released. Codes are offset binary, so 0x2000 is the zero level.

Top module: `oct_dac_front`

## Requirements
- R1: After reset, every channel's output code is 0x2000 (offset-binary zero) and all force flags are 0.
- R2: While both chip-select and write are low, the input register addressed by the 3-bit channel address follows the data bus. If either strobe is high, no input register changes.
- R3: When chip-select rises, the addressed input register keeps the data that was on the bus just before the rise. Later bus changes have no effect on it.
- R4: A write changes only the channel whose number equals the address, with bit 2 as the MSB. Channels 0 and 7 are both reachable.
- R5: While load is high, output codes hold even when input registers change. While load is low, every output code follows its own input register.
- R6: If load is low during a write, the addressed output code takes the new data in the same cycle as the input register does.
- R7: While clear is low, all eight force flags are 1 and the output codes keep their values.
- R8: Clear leaves both register ranks unchanged, and writes made during clear still reach the input registers. When clear returns high, the force flags return to 0 and each channel presents its held code.
- R9: An output responds on the third rising clock edge after the input change: two synchronizer stages, then one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 14 | Code bus, offset binary |
| addr_i | input | 3 | Channel address |
| cs_ni | input | 1 | Chip-select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ld_ni | input | 1 | Global load, active low, level sensitive |
| clr_ni | input | 1 | Clear override, active low |
| code_o | output | 112 | Eight output codes; channel n occupies bits n*14 +: 14 |
| force_o | output | 8 | Per-channel force-to-ground flags |

## Verification
Every result appears on the third rising edge after the bus or strobe change that causes it: two edges to pass the synchronizer and one for the register rank. This holds for the input rank, for the output rank when load is already low, and for the force flags. The driver changes inputs on a falling edge. It waits at least three rising edges before it queues expected values, and the monitor compares them on the next falling edge. One directed case queues the old value after two edges and the new value after three, which pins the latency to the exact cycle.

// File: rtl/oct_dac_pkg.sv
package oct_dac_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  localparam int unsigned DEF_CODE_W = 14;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // offset-binary zero: MSB set, rest clear
  function automatic logic [31:0] midscale(input int unsigned width);
    return 32'(1) << (width - 1);
  endfunction
endpackage

// File: rtl/oct_dac_sync.sv
module oct_dac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/oct_dac_in_rank.sv
module oct_dac_in_rank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14,
  localparam int unsigned ADDR_W = $clog2(NUM_CH),
  localparam int unsigned FLAT_W = NUM_CH * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [FLAT_W-1:0] in_q_o,
  output logic [FLAT_W-1:0] in_d_o   // next-state, feeds the output rank
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(oct_dac_pkg::midscale(CODE_W));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              sel;
    logic [CODE_W-1:0] q_r;
    logic [CODE_W-1:0] d_c;

    assign sel = wr_en_i && (addr_i == ADDR_W'(ch));
    assign d_c = sel ? data_i : q_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= MID;
      else         q_r <= d_c;
    end

    assign in_q_o[ch*CODE_W +: CODE_W] = q_r;
    assign in_d_o[ch*CODE_W +: CODE_W] = d_c;
  end
endmodule

// File: rtl/oct_dac_out_rank.sv
module oct_dac_out_rank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14,
  localparam int unsigned FLAT_W = NUM_CH * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic              clr_act_i,
  input  logic [FLAT_W-1:0] in_d_i,
  output logic [FLAT_W-1:0] code_o,
  output logic [NUM_CH-1:0] force_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(oct_dac_pkg::midscale(CODE_W));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] q_r;
    logic              frc_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_r <= MID;
      else if (ld_en_i) q_r <= in_d_i[ch*CODE_W +: CODE_W];
    end

    // clear only flags the channel; the stored code is untouched
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) frc_r <= 1'b0;
      else         frc_r <= clr_act_i;
    end

    assign code_o[ch*CODE_W +: CODE_W] = q_r;
    assign force_o[ch] = frc_r;
  end
endmodule

// File: rtl/oct_dac_front.sv
module oct_dac_front #(
  parameter int unsigned NUM_CH      = oct_dac_pkg::DEF_NUM_CH,
  parameter int unsigned CODE_W      = oct_dac_pkg::DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = oct_dac_pkg::DEF_SYNC_STAGES,
  localparam int unsigned ADDR_W = $clog2(NUM_CH),
  localparam int unsigned FLAT_W = NUM_CH * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              ld_ni,
  input  logic              clr_ni,
  output logic [FLAT_W-1:0] code_o,
  output logic [NUM_CH-1:0] force_o
);
  logic              cs_s, wr_s, ld_s, clr_s;
  logic [ADDR_W-1:0] addr_s;
  logic [CODE_W-1:0] data_s;
  logic [FLAT_W-1:0] in_q, in_d;
  logic              wr_en;

  oct_dac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) i_sync_strb (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, wr_ni, ld_ni, clr_ni}),
    .q_o ({cs_s, wr_s, ld_s, clr_s})
  );

  oct_dac_sync #(.W(ADDR_W + CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_bus (
    .clk_i, .rst_ni,
    .d_i ({addr_i, data_i}),
    .q_o ({addr_s, data_s})
  );

  assign wr_en = !cs_s && !wr_s;

  oct_dac_in_rank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_in_rank (
    .clk_i, .rst_ni,
    .wr_en_i (wr_en),
    .addr_i  (addr_s),
    .data_i  (data_s),
    .in_q_o  (in_q),
    .in_d_o  (in_d)
  );

  oct_dac_out_rank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_out_rank (
    .clk_i, .rst_ni,
    .ld_en_i   (!ld_s),
    .clr_act_i (!clr_s),
    .in_d_i    (in_d),
    .code_o    (code_o),
    .force_o   (force_o)
  );
endmodule

// File: rtl/oct_dac_front_chk.sv
module oct_dac_front_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 14,
  localparam int unsigned ADDR_W = $clog2(NUM_CH),
  localparam int unsigned FLAT_W = NUM_CH * CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              wr_s,
  input logic              ld_s,
  input logic              clr_s,
  input logic [ADDR_W-1:0] addr_s,
  input logic [CODE_W-1:0] data_s,
  input logic [FLAT_W-1:0] in_q,
  input logic [FLAT_W-1:0] code_o,
  input logic [NUM_CH-1:0] force_o
);
  assert_write_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !wr_s) |=> in_q[$past(addr_s)*CODE_W +: CODE_W] == $past(data_s));

  assert_idle_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s || wr_s) |=> $stable(in_q));

  assert_load_high_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_s |=> $stable(code_o));

  assert_same_cycle_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_s && !cs_s && !wr_s) |=> code_o[$past(addr_s)*CODE_W +: CODE_W] == $past(data_s));

  assert_clear_forces_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> force_o == {NUM_CH{1'b1}});

  assert_clear_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> force_o == '0);
endmodule

bind oct_dac_front oct_dac_front_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .wr_s    (wr_s),
  .ld_s    (ld_s),
  .clr_s   (clr_s),
  .addr_s  (addr_s),
  .data_s  (data_s),
  .in_q    (in_q),
  .code_o  (code_o),
  .force_o (force_o)
);

// File: tb/test_oct_dac_front.sv
`timescale 1ns/1ps
module test_oct_dac_front;
  localparam int NCH = 8;
  localparam int CW  = 14;
  localparam int LAT = 3;
  localparam logic [CW-1:0] MID = 14'h2000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [CW-1:0]   data_i = '0;
  logic [2:0]      addr_i = '0;
  logic            cs_ni = 1'b1, wr_ni = 1'b1, ld_ni = 1'b1, clr_ni = 1'b1;
  logic [NCH*CW-1:0] code_o;
  logic [NCH-1:0]  force_o;

  always #2.5 clk_i = ~clk_i;

  oct_dac_front i_oct_dac_front (
    .clk_i, .rst_ni, .data_i, .addr_i, .cs_ni, .wr_ni, .ld_ni, .clr_ni,
    .code_o, .force_o
  );

  typedef struct {
    string         tag;
    int            ch;
    logic [CW-1:0] code;
    logic          frc;
  } exp_t;

  exp_t          q[$];
  logic [CW-1:0] in_ref  [NCH];
  logic [CW-1:0] out_ref [NCH];
  logic          clr_ref;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [CW-1:0] got;
      e = q.pop_front();
      got = code_o[e.ch*CW +: CW];
      checks++;
      if (got !== e.code || force_o[e.ch] !== e.frc) begin
        errors++;
        $display("FAIL %s ch%0d: code=%h force=%b expected code=%h force=%b",
                 e.tag, e.ch, got, force_o[e.ch], e.code, e.frc);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic push_all(string tag);
    for (int c = 0; c < NCH; c++) q.push_back('{tag, c, out_ref[c], clr_ref});
  endtask

  task automatic settle_and_check(string tag);
    @(negedge clk_i);
    cyc(LAT + 1);
    push_all(tag);
  endtask

  // full write cycle; bus changes right after chip-select rises (R3)
  task automatic write(int ch, logic [CW-1:0] d);
    @(negedge clk_i);
    addr_i = 3'(ch); data_i = d; cs_ni = 0; wr_ni = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    cs_ni = 1; wr_ni = 1;
    @(negedge clk_i);
    data_i = ~d; addr_i = 3'(ch + 1);
    in_ref[ch] = d;
    if (!ld_ni) for (int c = 0; c < NCH; c++) out_ref[c] = in_ref[c];
  endtask

  task automatic load_pulse();
    @(negedge clk_i);
    ld_ni = 0;
    @(negedge clk_i);
    ld_ni = 1;
    for (int c = 0; c < NCH; c++) out_ref[c] = in_ref[c];
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin in_ref[c] = MID; out_ref[c] = MID; end
    clr_ref = 0;
    cyc(3);
    rst_ni = 1;
    settle_and_check("R1 reset midscale");

    write(3, 14'h1234);
    settle_and_check("R5 hold while load high / R4");
    load_pulse();
    settle_and_check("R5 load transfer");

    write(5, 14'h0abc);
    load_pulse();
    settle_and_check("R3 commit on chip-select rise");

    // write strobe low with chip-select high: no effect (R2)
    @(negedge clk_i);
    addr_i = 3'd2; data_i = 14'h3333; cs_ni = 1; wr_ni = 0;
    cyc(LAT + 1);
    wr_ni = 1;
    load_pulse();
    settle_and_check("R2 ignored without chip-select");

    // load held low (R6), address extremes (R4)
    @(negedge clk_i); ld_ni = 0;
    write(0, 14'h3fff);
    settle_and_check("R6 write with load low ch0");
    write(7, 14'h0000);
    settle_and_check("R6 write with load low ch7 R4");

    // latency R9: change on negedge, old after 2 edges, new after 3
    @(negedge clk_i);
    addr_i = 3'd4; data_i = 14'h2a5a; cs_ni = 0; wr_ni = 0;
    cyc(2);
    q.push_back('{"R9 not before third edge", 4, out_ref[4], clr_ref});
    cyc(1);
    q.push_back('{"R9 on third edge", 4, 14'h2a5a, clr_ref});
    @(negedge clk_i); cs_ni = 1; wr_ni = 1;
    in_ref[4] = 14'h2a5a; out_ref[4] = 14'h2a5a;
    @(negedge clk_i); ld_ni = 1;
    settle_and_check("R5 after load release");

    // clear: force on, codes kept (R7)
    @(negedge clk_i); clr_ni = 0; clr_ref = 1;
    settle_and_check("R7 clear forces, codes kept");
    write(1, 14'h1111);
    settle_and_check("R8 write during clear keeps outputs");
    @(negedge clk_i); clr_ni = 1; clr_ref = 0;
    settle_and_check("R8 clear release restores");
    load_pulse();
    settle_and_check("R8 input survives clear");

    // clear asserted while load low
    @(negedge clk_i); ld_ni = 0; clr_ni = 0; clr_ref = 1;
    write(6, 14'h0001);
    settle_and_check("R7 clear with load low");
    @(negedge clk_i); ld_ni = 1; clr_ni = 1; clr_ref = 0;
    settle_and_check("R8 final state");

    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule